// File: doc/BRIEF.md
# Power-On Self-Test Blink Sequencer

This block runs the start-up self-test of a small controller board and reports the outcome on a single LED. After reset it gives one blink to show it is alive. It then starts four test engines one after another: the program-memory checksum, the working-RAM test, the nonvolatile-memory checksum and a status query of the peripheral controller. Each engine is reached through a start strobe and answers with a done strobe and a pass level. The engines themselves sit outside the block.

Failures are not all alike. A bad program memory, RAM or peripheral controller gives a coded blink burst and halts the board. A bad nonvolatile checksum gives its own code, asks for the checksum to be rewritten to match the stored contents, and lets the start-up go on. A hard-fault flag is raised only when the same failure was also seen on the previous power-up. An outside model keeps that history bit across power cycles. Last, the block reads the four game-select switches. If the selected game is not in the supported mask, it gives a five-blink code and enters a limited mode. The board is then released to run no earlier than a set number of ticks after the first blink.

Top module: `post_blink_seq`

## Requirements
- R1: While reset is held, `led`, `runEn`, `limitedMode`, `hardFault`, `nvRecompute`, `nvFailNow` and every `testStart` bit are low, and both display digits show the blank code 4'hF.
- R2: Before any test starts, the LED gives exactly one blink.
- R3: Test engines are started one at a time, by a single-cycle strobe on `testStart` bit 0 (program memory), 1 (RAM), 2 (nonvolatile) and 3 (peripheral), in that order. Each engine starts only after the one before it has reported done and pass.
- R4: A failure of engine 0, 1 or 3 adds 1, 2 or 4 blinks after the alive blink. No further engine is started, and `runEn` stays low.
- R5: A failure of engine 2 adds 3 blinks, gives exactly one `nvRecompute` pulse, sets `nvFailNow`, and lets the sequence go on to engine 3.
- R6: `hardFault` rises only when engine 2 fails while `nvPrevFail` is high. A single failure leaves it low.
- R7: `gameSel` is read as a binary game number. When the bit of `gameMask` at that index is 1, the display shows the number as two decimal digits and `limitedMode` stays low.
- R8: When the bit of `gameMask` at that index is 0, the LED gives 5 more blinks, `limitedMode` goes high, both digits show 9, and `runEn` still goes high.
- R9: `runEn` does not rise until at least TOTAL_TICKS cycles after the alive blink has ended. Once high, it stays high.
- R10: Every blink holds the LED high for exactly ON_TICKS cycles. Two blinks are separated by at least OFF_TICKS low cycles, and a code burst is preceded by a gap of GAP_TICKS low cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset (a power-up) |
| testDone | input | 4 | Done strobe from each test engine |
| testPass | input | 4 | Pass level from each engine, read together with its done strobe |
| gameSel | input | GAME_W | Game-select switches, binary |
| gameMask | input | 2**GAME_W | One bit per game number, 1 when the game is supported |
| nvPrevFail | input | 1 | Nonvolatile check failed on the previous power-up |
| testStart | output | 4 | Single-cycle start strobe per engine |
| led | output | 1 | Status LED |
| runEn | output | 1 | Board released to operate |
| limitedMode | output | 1 | Unsupported game: bookkeeping and diagnostics only |
| nvRecompute | output | 1 | Pulse asking for the nonvolatile checksum to be rewritten |
| hardFault | output | 1 | Nonvolatile check failed on two power-ups in a row |
| nvFailNow | output | 1 | Nonvolatile result of this power-up, for the history holder |
| dispTens | output | 4 | Tens digit of the game display |
| dispOnes | output | 4 | Ones digit of the game display |

## Verification
A start strobe appears one cycle after the previous engine's done strobe is sampled. The LED rises one cycle after a blink is launched, while `nvRecompute` and the display digits change on the cycle after the sequencer reaches the step that sets them. `runEn` follows once the elapsed counter reaches TOTAL_TICKS. Because these delays depend on how quickly the engines answer and on how long each blink burst lasts, the bench does not compare single cycles. It samples every output on the falling edge and keeps running observations of each power-up: blink rises, high and low run lengths, the order of start strobes, recompute pulses, and the cycle on which `runEn` first rises. It compares the totals with the expected items after a fixed window that is longer than the slowest path through the sequence.

// File: rtl/post_seq_pkg.sv
package post_seq_pkg;

  localparam int NumTests = 4;

  typedef enum logic [3:0] {
    S_ALIVE, S_ALIVE_W, S_START, S_WAIT, S_NVCODE, S_HALT,
    S_GAME, S_GAMECODE, S_HOLD, S_RUN
  } seqState_t;

  typedef enum logic [1:0] {B_IDLE, B_GAP, B_ON, B_OFF} blinkPhase_t;

  typedef struct packed {
    logic       blinkGo;
    logic [2:0] blinkCount;
    logic       useGap;
    logic       elapsedGo;
    logic       latchGame;
    logic       nvFail;
    logic       runSet;
  } ctrlStrobe_t;

endpackage

// File: rtl/post_blink_gen.sv
module post_blink_gen #(
  parameter int ON_TICKS  = 4,
  parameter int OFF_TICKS = 4,
  parameter int GAP_TICKS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       go,
  input  logic [2:0] count,
  input  logic       useGap,
  output logic       led,
  output logic       busy
);
  import post_seq_pkg::*;

  localparam int MaxOnOff = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int MaxT     = (MaxOnOff > GAP_TICKS) ? MaxOnOff : GAP_TICKS;
  localparam int TW       = $clog2(MaxT + 1);

  blinkPhase_t phase;
  logic [TW-1:0] tmr;
  logic [2:0]    remain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= B_IDLE;
      tmr    <= '0;
      remain <= '0;
    end else if (go) begin
      remain <= count;
      if (useGap) begin
        phase <= B_GAP;
        tmr   <= TW'(GAP_TICKS - 1);
      end else begin
        phase <= B_ON;
        tmr   <= TW'(ON_TICKS - 1);
      end
    end else begin
      case (phase)
        B_GAP: begin
          if (tmr == '0) begin
            phase <= B_ON;
            tmr   <= TW'(ON_TICKS - 1);
          end else tmr <= tmr - 1'b1;
        end
        B_ON: begin
          if (tmr == '0) begin
            phase  <= B_OFF;
            tmr    <= TW'(OFF_TICKS - 1);
            remain <= remain - 3'd1;
          end else tmr <= tmr - 1'b1;
        end
        B_OFF: begin
          if (tmr == '0) begin
            if (remain == '0) phase <= B_IDLE;
            else begin
              phase <= B_ON;
              tmr   <= TW'(ON_TICKS - 1);
            end
          end else tmr <= tmr - 1'b1;
        end
        default: phase <= B_IDLE;
      endcase
    end
  end

  assign led  = (phase == B_ON);
  assign busy = (phase != B_IDLE);

endmodule

// File: rtl/post_datapath.sv
module post_datapath #(
  parameter int ON_TICKS    = 4,
  parameter int OFF_TICKS   = 4,
  parameter int GAP_TICKS   = 8,
  parameter int TOTAL_TICKS = 64,
  parameter int GAME_W      = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  post_seq_pkg::ctrlStrobe_t stb,
  input  logic [GAME_W-1:0]        gameSel,
  input  logic [(1<<GAME_W)-1:0]   gameMask,
  input  logic                     nvPrevFail,
  output logic                     led,
  output logic                     blinkBusy,
  output logic                     gameOk,
  output logic                     elapsedDone,
  output logic                     runEn,
  output logic                     limitedMode,
  output logic                     nvRecompute,
  output logic                     hardFault,
  output logic                     nvFailNow,
  output logic [3:0]               dispTens,
  output logic [3:0]               dispOnes
);
  localparam int EW = $clog2(TOTAL_TICKS + 1);

  logic [EW-1:0] elapsed;
  logic          elapsedRun;
  logic [3:0]    gameTens, gameOnes;

  post_blink_gen #(
    .ON_TICKS(ON_TICKS), .OFF_TICKS(OFF_TICKS), .GAP_TICKS(GAP_TICKS)
  ) uBlink (
    .clk(clk), .rstN(rstN), .go(stb.blinkGo), .count(stb.blinkCount),
    .useGap(stb.useGap), .led(led), .busy(blinkBusy)
  );

  assign gameOk      = gameMask[gameSel];
  assign gameTens    = 4'(int'(gameSel) / 10);
  assign gameOnes    = 4'(int'(gameSel) % 10);
  assign elapsedDone = elapsedRun && (elapsed == EW'(TOTAL_TICKS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsed    <= '0;
      elapsedRun <= 1'b0;
    end else begin
      if (stb.elapsedGo) elapsedRun <= 1'b1;
      if (elapsedRun && elapsed != EW'(TOTAL_TICKS)) elapsed <= elapsed + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn       <= 1'b0;
      limitedMode <= 1'b0;
      nvRecompute <= 1'b0;
      hardFault   <= 1'b0;
      nvFailNow   <= 1'b0;
      dispTens    <= 4'hF;
      dispOnes    <= 4'hF;
    end else begin
      nvRecompute <= stb.nvFail;
      if (stb.nvFail) begin
        nvFailNow <= 1'b1;
        hardFault <= nvPrevFail;
      end
      if (stb.latchGame) begin
        if (gameOk) begin
          dispTens    <= gameTens;
          dispOnes    <= gameOnes;
          limitedMode <= 1'b0;
        end else begin
          dispTens    <= 4'd9;
          dispOnes    <= 4'd9;
          limitedMode <= 1'b1;
        end
      end
      if (stb.runSet) runEn <= 1'b1;
    end
  end

endmodule

// File: rtl/post_ctrl.sv
module post_ctrl (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [3:0]                testDone,
  input  logic [3:0]                testPass,
  input  logic                      blinkBusy,
  input  logic                      gameOk,
  input  logic                      elapsedDone,
  output logic [3:0]                testStart,
  output post_seq_pkg::ctrlStrobe_t stb
);
  import post_seq_pkg::*;

  localparam logic [1:0] NvIdx   = 2'd2;
  localparam logic [1:0] LastIdx = 2'(NumTests - 1);

  seqState_t state, nxt;
  logic [1:0] idx, idxNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_ALIVE;
      idx   <= '0;
    end else begin
      state <= nxt;
      idx   <= idxNxt;
    end
  end

  always_comb begin
    nxt       = state;
    idxNxt    = idx;
    stb       = '0;
    testStart = '0;
    case (state)
      S_ALIVE: begin
        stb.blinkGo    = 1'b1;
        stb.blinkCount = 3'd1;
        nxt            = S_ALIVE_W;
      end
      S_ALIVE_W: if (!blinkBusy) begin
        stb.elapsedGo = 1'b1;
        idxNxt        = '0;
        nxt           = S_START;
      end
      S_START: begin
        testStart[idx] = 1'b1;
        nxt            = S_WAIT;
      end
      S_WAIT: if (testDone[idx]) begin
        if (testPass[idx]) begin
          if (idx == LastIdx) nxt = S_GAME;
          else begin
            idxNxt = 2'(idx + 2'd1);
            nxt    = S_START;
          end
        end else begin
          stb.blinkGo    = 1'b1;
          stb.useGap     = 1'b1;
          stb.blinkCount = 3'({1'b0, idx} + 3'd1);
          if (idx == NvIdx) begin
            stb.nvFail = 1'b1;
            nxt        = S_NVCODE;
          end else nxt = S_HALT;
        end
      end
      S_NVCODE: if (!blinkBusy) begin
        idxNxt = 2'(idx + 2'd1);
        nxt    = S_START;
      end
      S_GAME: begin
        stb.latchGame = 1'b1;
        if (gameOk) nxt = S_HOLD;
        else begin
          stb.blinkGo    = 1'b1;
          stb.useGap     = 1'b1;
          stb.blinkCount = 3'd5;
          nxt            = S_GAMECODE;
        end
      end
      S_GAMECODE: if (!blinkBusy) nxt = S_HOLD;
      S_HOLD: if (elapsedDone) begin
        stb.runSet = 1'b1;
        nxt        = S_RUN;
      end
      S_HALT, S_RUN: nxt = state;
      default: nxt = S_ALIVE;
    endcase
  end

endmodule

// File: rtl/post_blink_seq.sv
module post_blink_seq #(
  parameter int ON_TICKS    = 819200,
  parameter int OFF_TICKS   = 819200,
  parameter int GAP_TICKS   = 1638400,
  parameter int TOTAL_TICKS = 19660800,
  parameter int GAME_W      = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [3:0]             testDone,
  input  logic [3:0]             testPass,
  input  logic [GAME_W-1:0]      gameSel,
  input  logic [(1<<GAME_W)-1:0] gameMask,
  input  logic                   nvPrevFail,
  output logic [3:0]             testStart,
  output logic                   led,
  output logic                   runEn,
  output logic                   limitedMode,
  output logic                   nvRecompute,
  output logic                   hardFault,
  output logic                   nvFailNow,
  output logic [3:0]             dispTens,
  output logic [3:0]             dispOnes
);
  import post_seq_pkg::*;

  ctrlStrobe_t stb;
  logic blinkBusy, gameOk, elapsedDone;

  post_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .testDone(testDone), .testPass(testPass),
    .blinkBusy(blinkBusy), .gameOk(gameOk), .elapsedDone(elapsedDone),
    .testStart(testStart), .stb(stb)
  );

  post_datapath #(
    .ON_TICKS(ON_TICKS), .OFF_TICKS(OFF_TICKS), .GAP_TICKS(GAP_TICKS),
    .TOTAL_TICKS(TOTAL_TICKS), .GAME_W(GAME_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .gameSel(gameSel), .gameMask(gameMask),
    .nvPrevFail(nvPrevFail), .led(led), .blinkBusy(blinkBusy), .gameOk(gameOk),
    .elapsedDone(elapsedDone), .runEn(runEn), .limitedMode(limitedMode),
    .nvRecompute(nvRecompute), .hardFault(hardFault), .nvFailNow(nvFailNow),
    .dispTens(dispTens), .dispOnes(dispOnes)
  );

endmodule

// File: rtl/post_blink_seq_chk.sv
module post_blink_seq_chk #(
  parameter int ON_TICKS    = 4,
  parameter int OFF_TICKS   = 4,
  parameter int TOTAL_TICKS = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic       led,
  input logic [3:0] testStart,
  input logic       runEn,
  input logic       limitedMode,
  input logic [3:0] dispTens,
  input logic [3:0] dispOnes,
  input logic       hardFault,
  input logic       nvPrevFail,
  input logic       nvRecompute
);
  logic [31:0] cyc, onRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cyc   <= '0;
      onRun <= '0;
    end else begin
      if (cyc != 32'hFFFF_FFFF) cyc <= cyc + 1;
      onRun <= led ? onRun + 1 : '0;
    end
  end

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rstN) $onehot0(testStart)); // R3
  AST_NO_START_RUN: assert property (@(posedge clk) disable iff (!rstN) runEn |-> testStart == 4'd0); // R3
  AST_RECOMP_PULSE: assert property (@(posedge clk) disable iff (!rstN) nvRecompute |=> !nvRecompute); // R5
  AST_HARD_NEEDS_PREV: assert property (@(posedge clk) disable iff (!rstN) hardFault |-> nvPrevFail); // R6
  AST_LIMIT_SHOWS_99: assert property (@(posedge clk) disable iff (!rstN) limitedMode |-> (dispTens == 4'd9 && dispOnes == 4'd9)); // R8
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rstN) runEn |=> runEn); // R9
  AST_RUN_NOT_EARLY: assert property (@(posedge clk) disable iff (!rstN) runEn |-> cyc >= 32'(ON_TICKS + OFF_TICKS + TOTAL_TICKS)); // R9
  AST_BLINK_WIDTH: assert property (@(posedge clk) disable iff (!rstN) $fell(led) |-> onRun == 32'(ON_TICKS)); // R10

endmodule

bind post_blink_seq post_blink_seq_chk #(
  .ON_TICKS(ON_TICKS), .OFF_TICKS(OFF_TICKS), .TOTAL_TICKS(TOTAL_TICKS)
) uChk (
  .clk(clk), .rstN(rstN), .led(led), .testStart(testStart), .runEn(runEn),
  .limitedMode(limitedMode), .dispTens(dispTens), .dispOnes(dispOnes),
  .hardFault(hardFault), .nvPrevFail(nvPrevFail), .nvRecompute(nvRecompute)
);

// File: tb/sim_post_blink_seq.sv
`timescale 1ns/100ps
module sim_post_blink_seq;
  localparam int OnT = 3, OffT = 2, GapT = 4, TotT = 300, Window = 500;

  logic clk = 1'b0, rstN = 1'b0;
  logic [3:0] testDone = '0, testPass = '1, testStart;
  logic [3:0] gameSel = '0;
  logic [15:0] gameMask = '1;
  logic nvPrevFail = 1'b0;
  logic led, runEn, limitedMode, nvRecompute, hardFault, nvFailNow;
  logic [3:0] dispTens, dispOnes;

  always #2.5 clk = ~clk;

  post_blink_seq #(.ON_TICKS(OnT), .OFF_TICKS(OffT), .GAP_TICKS(GapT),
                   .TOTAL_TICKS(TotT), .GAME_W(4)) u0 (
    .clk(clk), .rstN(rstN), .testDone(testDone), .testPass(testPass),
    .gameSel(gameSel), .gameMask(gameMask), .nvPrevFail(nvPrevFail),
    .testStart(testStart), .led(led), .runEn(runEn), .limitedMode(limitedMode),
    .nvRecompute(nvRecompute), .hardFault(hardFault), .nvFailNow(nvFailNow),
    .dispTens(dispTens), .dispOnes(dispOnes)
  );

  typedef struct {
    string name; int blinks; bit run; bit lim; bit hard; bit nvOut;
    int recomp; logic [3:0] tens; logic [3:0] ones; logic [15:0] starts;
  } expect_t;

  expect_t q[$];
  event evCheck;
  int total = 0, bad = 0;

  // observations of one power-up
  bit observing = 0;
  int cyc, rises, hiLen, loLen, firstFall, runAt, recompCnt;
  bit ledPrev, shapeBad;
  logic [15:0] startLog;

  task automatic chk(string req, bit ok, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // test engine model: done three cycles after start
  int engDelay = 0, engIdx = 0;
  initial forever begin
    @(negedge clk);
    testDone = '0;
    if (engDelay > 0) begin
      engDelay--;
      if (engDelay == 0) testDone[engIdx] = 1'b1;
    end
    for (int i = 0; i < 4; i++) if (testStart[i]) begin engIdx = i; engDelay = 3; end
  end

  // monitor: gather observations on falling edges
  initial forever begin
    @(negedge clk);
    if (observing) begin
      cyc++;
      if (led && !ledPrev) begin
        if (rises > 0 && loLen < OffT) shapeBad = 1;
        rises++;
        hiLen = 0;
      end
      if (!led && ledPrev) begin
        if (hiLen != OnT) shapeBad = 1;
        if (firstFall < 0) firstFall = cyc;
        loLen = 0;
      end
      if (led) hiLen++; else loLen++;
      ledPrev = led;
      for (int i = 0; i < 4; i++) if (testStart[i]) startLog = {startLog[11:0], 4'(i + 1)};
      if (nvRecompute) recompCnt++;
      if (runEn && runAt < 0) runAt = cyc;
    end
  end

  // scoreboard compare
  initial forever begin
    expect_t e;
    @(evCheck);
    e = q.pop_front();
    chk({"R2/R4/R5/R8 blinks ", e.name}, rises == e.blinks, rises, e.blinks);
    chk({"R3 start order ", e.name}, startLog == e.starts, int'(startLog), int'(e.starts));
    chk({"R4/R9 runEn ", e.name}, runEn == e.run, int'(runEn), int'(e.run));
    chk({"R7/R8 limitedMode ", e.name}, limitedMode == e.lim, int'(limitedMode), int'(e.lim));
    chk({"R6 hardFault ", e.name}, hardFault == e.hard, int'(hardFault), int'(e.hard));
    chk({"R5 nvFailNow ", e.name}, nvFailNow == e.nvOut, int'(nvFailNow), int'(e.nvOut));
    chk({"R5 recompute pulses ", e.name}, recompCnt == e.recomp, recompCnt, e.recomp);
    chk({"R7 tens ", e.name}, dispTens == e.tens, int'(dispTens), int'(e.tens));
    chk({"R7 ones ", e.name}, dispOnes == e.ones, int'(dispOnes), int'(e.ones));
    chk({"R10 blink shape ", e.name}, !shapeBad, int'(shapeBad), 0);
    if (e.run)
      chk({"R9 release time ", e.name}, runAt - firstFall >= TotT, runAt - firstFall, TotT);
  end

  // driver: one simulated power-up
  task automatic powerUp(string name, logic [3:0] pass, logic [3:0] game,
                         logic [15:0] mask, bit prev);
    expect_t e;
    int fatal = -1;
    bit nvBad = !pass[2];
    bit ok = mask[game];
    for (int i = 0; i < 4; i++) if (!pass[i] && i != 2 && fatal < 0) fatal = i;
    e.name = name;
    e.starts = '0;
    for (int i = 0; i < 4; i++)
      if (fatal < 0 || i <= fatal) e.starts = {e.starts[11:0], 4'(i + 1)};
    if (fatal >= 0) begin
      e.blinks = 1 + fatal + 1 + ((nvBad && fatal == 3) ? 3 : 0);
      e.run = 0; e.lim = 0; e.tens = 4'hF; e.ones = 4'hF;
    end else begin
      e.blinks = 1 + (nvBad ? 3 : 0) + (ok ? 0 : 5);
      e.run = 1; e.lim = !ok;
      e.tens = ok ? 4'(game / 10) : 4'd9;
      e.ones = ok ? 4'(game % 10) : 4'd9;
    end
    e.nvOut  = nvBad && (fatal < 0 || fatal == 3);
    e.hard   = e.nvOut && prev;
    e.recomp = e.nvOut ? 1 : 0;
    q.push_back(e);

    @(negedge clk);
    rstN = 1'b0; observing = 0;
    testPass = pass; gameSel = game; gameMask = mask; nvPrevFail = prev;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 led in reset", led == 1'b0, int'(led), 0);
    chk("R1 runEn in reset", runEn == 1'b0 && testStart == 4'd0, int'({runEn, testStart}), 0);
    chk("R1 flags in reset", {limitedMode, hardFault, nvRecompute, nvFailNow} == 4'd0,
        int'({limitedMode, hardFault, nvRecompute, nvFailNow}), 0);
    chk("R1 blank display", {dispTens, dispOnes} == 8'hFF, int'({dispTens, dispOnes}), 255);
    cyc = 0; rises = 0; hiLen = 0; loLen = 0; firstFall = -1; runAt = -1;
    recompCnt = 0; ledPrev = 0; shapeBad = 0; startLog = '0;
    rstN = 1'b1; observing = 1;
    repeat (Window) @(negedge clk);
    ->evCheck;
    @(negedge clk);
  endtask

  initial begin
    powerUp("all pass game 5", 4'b1111, 4'd5, 16'hFFFF, 1'b0);
    powerUp("program fail", 4'b1110, 4'd5, 16'hFFFF, 1'b0);
    powerUp("ram fail", 4'b1101, 4'd5, 16'hFFFF, 1'b0);
    powerUp("peripheral fail", 4'b0111, 4'd5, 16'hFFFF, 1'b0);
    powerUp("nv fail once game 12", 4'b1011, 4'd12, 16'hFFFF, 1'b0);
    powerUp("nv fail twice unsupported 3", 4'b1011, 4'd3, 16'hFFF7, 1'b1);
    powerUp("unsupported game 0", 4'b1111, 4'd0, 16'hFFFE, 1'b1);
    powerUp("all pass game 15", 4'b1111, 4'd15, 16'h8000, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule